// File: doc/BRIEF.md
# Byte ALU with Zero and Carry Flags

This block is the arithmetic and logic stage of a small 8-bit controller core. Each cycle it takes a destination operand, a second operand (which may be a register value or an immediate constant), a 4-bit operation code and a 3-bit shift-fill selector. From these it forms a result and a write-back enable for the register file. It also produces the next zero and carry values and an update enable for each flag.

The zero and carry flags are stored inside the block. The stored carry feeds the carry-consuming add and subtract operations and the carry-fill shift. Flags change only on a rising clock edge in a cycle where `exec_en` is high and the operation is one that updates them. Instruction decode, the register file and the data memory belong to other blocks.

Operation codes on `op`:
- 0 load
- 1 and
- 2 or
- 3 xor
- 4 add
- 5 add-with-carry
- 6 subtract
- 7 subtract-with-borrow
- 8 test
- 9 compare
- 10 shift left
- 11 shift right
- 12 rotate left
- 13 rotate right
- 14 and 15 unassigned

Top module: `byte_alu`

## Requirements
- R1: Load (op 0) drives `result` = `opnd_b` with `result_we` high. It raises neither `zero_we` nor `carry_we`, so both stored flags keep their value.
- R2: And, or and xor (ops 1, 2, 3) write the bitwise result back. They clear carry and set zero exactly when the 8-bit result is 0.
- R3: Add (op 4) sets carry when `opnd_a + opnd_b` exceeds 255. Subtract (op 6) sets carry when `opnd_a - opnd_b` is below 0. Both write the 8-bit result back and set zero when it is 0.
- R4: Add-with-carry (op 5) computes a + b + C and subtract-with-borrow (op 7) computes a − b − C, where C is the stored carry flag. Carry follows the R3 rules. Zero reflects only the new 8-bit result and ignores the previous zero flag.
- R5: Test (op 8) writes nothing back. It sets zero when `opnd_a & opnd_b` is 0 and sets carry to the XOR reduction (odd parity) of `opnd_a & opnd_b`.
- R6: Compare (op 9) writes nothing back and sets zero and carry exactly as subtract would for the same operands.
- R7: Shift left (op 10) gives `{a[6:0], fill}` and shift right (op 11) gives `{fill, a[7:1]}`. The bit shifted out goes to carry, and zero is set when the result is 0. `shift_fill` selects the fill bit: 0 gives 0, 1 gives 1, 2 gives the stored carry, 3 gives the end bit being vacated (a[0] for left, a[7] for right), and codes 4 to 7 give 0.
- R8: Rotate left (op 12) gives `{a[6:0], a[7]}` with carry = a[7]. Rotate right (op 13) gives `{a[0], a[7:1]}` with carry = a[0]. Both ignore `shift_fill`, write back, and update zero.
- R9: The stored flags change only on a clock edge where their update enable is high, and each then takes the next value offered in that cycle. With `exec_en` low, `result_we`, `zero_we` and `carry_we` are all low.
- R10: Reset (`rst_n` low) clears both stored flags.
- R11: Ops 14 and 15 raise none of `result_we`, `zero_we` or `carry_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| exec_en | input | 1 | An operation executes in this cycle |
| op | input | 4 | Operation code (see table above) |
| shift_fill | input | 3 | Fill-bit selector for shift operations |
| opnd_a | input | 8 | Destination register value |
| opnd_b | input | 8 | Second register value or immediate constant |
| result | output | 8 | Combinational result |
| result_we | output | 1 | Write the result to the destination register |
| zero_d | output | 1 | Next zero flag value |
| carry_d | output | 1 | Next carry flag value |
| zero_we | output | 1 | Zero flag updates at the next edge |
| carry_we | output | 1 | Carry flag updates at the next edge |
| zero_q | output | 1 | Stored zero flag |
| carry_q | output | 1 | Stored carry flag |

## Verification
In one cycle, a carry-consuming operation (add-with-carry, subtract-with-borrow or the carry-fill shift) reads the stored carry while that same carry is being overwritten at the coming edge. This is provoked with back-to-back chains: an add that overflows, followed at once by add-with-carry or subtract-with-borrow, and carry-fill shifts repeated on consecutive cycles. Random sequences also produce many such adjacent pairs. Each step is judged against a bench model that carries its own flag copy forward one edge at a time, so that a design reading a stale or already-updated carry gives a wrong result or a wrong flag.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    typedef enum logic [3:0] {
        OP_LOAD = 4'd0,
        OP_AND  = 4'd1,
        OP_OR   = 4'd2,
        OP_XOR  = 4'd3,
        OP_ADD  = 4'd4,
        OP_ADDC = 4'd5,
        OP_SUB  = 4'd6,
        OP_SUBC = 4'd7,
        OP_TEST = 4'd8,
        OP_CMP  = 4'd9,
        OP_SHL  = 4'd10,
        OP_SHR  = 4'd11,
        OP_ROL  = 4'd12,
        OP_ROR  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_fn_e;

    typedef struct packed {
        logic zero;
        logic carry;
    } flag_t;

endpackage

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] res,
    output logic         and_parity
);

    logic [W-1:0] and_v;

    // per-bit structure: each lane is an independent gate trio
    for (genvar i = 0; i < W; i++) begin : g_lane
        always_comb begin
            and_v[i] = a[i] & b[i];
            unique case (fn)
                LG_OR:   res[i] = a[i] | b[i];
                LG_XOR:  res[i] = a[i] ^ b[i];
                default: res[i] = and_v[i];
            endcase
        end
    end

    assign and_parity = ^and_v;

endmodule

// File: rtl/byte_alu_arith.sv
module byte_alu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    input  logic         use_cin,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);

    localparam int XW = W + 1;

    logic [XW-1:0] ext_a;
    logic [XW-1:0] ext_b;
    logic [XW-1:0] ext_c;
    logic [XW-1:0] sum_w;
    logic [XW-1:0] dif_w;

    always_comb begin
        ext_a = {1'b0, a};
        ext_b = {1'b0, b};
        ext_c = {{W{1'b0}}, use_cin & cin};
        sum_w = ext_a + ext_b + ext_c;
        dif_w = ext_a - ext_b - ext_c;
        res   = do_sub ? dif_w[W-1:0] : sum_w[W-1:0];
        cout  = do_sub ? dif_w[W]     : sum_w[W];
    end

endmodule

// File: rtl/byte_alu_shift.sv
module byte_alu_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         left,
    input  logic         rotate,
    input  logic [2:0]   fill_sel,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);

    logic end_bit;
    logic fill_b;

    always_comb begin
        end_bit = left ? a[0] : a[W-1];
        unique case (fill_sel)
            3'd1:    fill_b = 1'b1;
            3'd2:    fill_b = cin;
            3'd3:    fill_b = end_bit;
            default: fill_b = 1'b0;
        endcase
        if (rotate) begin
            fill_b = left ? a[W-1] : a[0];
        end
        if (left) begin
            res  = {a[W-2:0], fill_b};
            cout = a[W-1];
        end else begin
            res  = {fill_b, a[W-1:1]};
            cout = a[0];
        end
    end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec_en,
    input  logic [3:0]   op,
    input  logic [2:0]   shift_fill,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         result_we,
    output logic         zero_d,
    output logic         carry_d,
    output logic         zero_we,
    output logic         carry_we,
    output logic         zero_q,
    output logic         carry_q
);

    alu_op_e      op_s;
    logic_fn_e    lg_fn;
    logic [W-1:0] lg_res;
    logic         lg_par;
    logic         ar_sub;
    logic         ar_cin;
    logic [W-1:0] ar_res;
    logic         ar_cout;
    logic         sh_left;
    logic         sh_rot;
    logic [W-1:0] sh_res;
    logic         sh_cout;
    logic         wr_raw;
    logic         fl_raw;
    flag_t        flg_d;
    flag_t        flg_q;

    assign op_s = alu_op_e'(op);

    always_comb begin
        unique case (op_s)
            OP_OR:   lg_fn = LG_OR;
            OP_XOR:  lg_fn = LG_XOR;
            default: lg_fn = LG_AND;
        endcase
        ar_sub  = (op_s == OP_SUB) || (op_s == OP_SUBC) || (op_s == OP_CMP);
        ar_cin  = (op_s == OP_ADDC) || (op_s == OP_SUBC);
        sh_left = (op_s == OP_SHL) || (op_s == OP_ROL);
        sh_rot  = (op_s == OP_ROL) || (op_s == OP_ROR);
    end

    byte_alu_logic #(.W(W)) u_logic (
        .a          (opnd_a),
        .b          (opnd_b),
        .fn         (lg_fn),
        .res        (lg_res),
        .and_parity (lg_par)
    );

    byte_alu_arith #(.W(W)) u_arith (
        .a       (opnd_a),
        .b       (opnd_b),
        .do_sub  (ar_sub),
        .use_cin (ar_cin),
        .cin     (flg_q.carry),
        .res     (ar_res),
        .cout    (ar_cout)
    );

    byte_alu_shift #(.W(W)) u_shift (
        .a        (opnd_a),
        .left     (sh_left),
        .rotate   (sh_rot),
        .fill_sel (shift_fill),
        .cin      (flg_q.carry),
        .res      (sh_res),
        .cout     (sh_cout)
    );

    // result selection and flag candidates
    always_comb begin
        result  = '0;
        carry_d = 1'b0;
        wr_raw  = 1'b0;
        fl_raw  = 1'b0;
        unique case (op_s)
            OP_LOAD: begin
                result = opnd_b;
                wr_raw = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result = lg_res;
                wr_raw = 1'b1;
                fl_raw = 1'b1;
            end
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
                result  = ar_res;
                carry_d = ar_cout;
                wr_raw  = 1'b1;
                fl_raw  = 1'b1;
            end
            OP_TEST: begin
                result  = lg_res;
                carry_d = lg_par;
                fl_raw  = 1'b1;
            end
            OP_CMP: begin
                result  = ar_res;
                carry_d = ar_cout;
                fl_raw  = 1'b1;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                result  = sh_res;
                carry_d = sh_cout;
                wr_raw  = 1'b1;
                fl_raw  = 1'b1;
            end
            default: begin
                result = '0;
            end
        endcase
        zero_d    = (result == '0);
        result_we = exec_en & wr_raw;
        zero_we   = exec_en & fl_raw;
        carry_we  = exec_en & fl_raw;
    end

    // flag next-state
    always_comb begin
        flg_d = flg_q;
        if (zero_we) begin
            flg_d.zero = zero_d;
        end
        if (carry_we) begin
            flg_d.carry = carry_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign zero_q  = flg_q.zero;
    assign carry_q = flg_q.carry;

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_we && !carry_we |=> (zero_q == $past(zero_q)) && (carry_q == $past(carry_q)));

    // R9
    flag_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_we && carry_we |=> (zero_q == $past(zero_d)) && (carry_q == $past(carry_d)));

    // R5
    test_cmp_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && (op_s == OP_TEST || op_s == OP_CMP) |-> !result_we && zero_we && carry_we);

    // R2
    logic_carry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_we && (op_s == OP_AND || op_s == OP_OR || op_s == OP_XOR) |-> !carry_d);

    // R3
    add_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_we && op_s == OP_ADD && !carry_d |-> result >= opnd_a);

    // R11
    undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_s == OP_RSV0 || op_s == OP_RSV1) |-> !result_we && !zero_we && !carry_we);

    // R1
    load_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_s == OP_LOAD |-> !zero_we && !carry_we);

endmodule

// File: tb/byte_alu_bench.sv
module byte_alu_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       exec_en;
    logic [3:0] op;
    logic [2:0] shift_fill;
    logic [7:0] opnd_a;
    logic [7:0] opnd_b;
    logic [7:0] result;
    logic       result_we;
    logic       zero_d;
    logic       carry_d;
    logic       zero_we;
    logic       carry_we;
    logic       zero_q;
    logic       carry_q;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic m_z = 1'b0;
    logic m_c = 1'b0;

    always #4 clk = ~clk;

    byte_alu u_byte_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_en    (exec_en),
        .op         (op),
        .shift_fill (shift_fill),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .result     (result),
        .result_we  (result_we),
        .zero_d     (zero_d),
        .carry_d    (carry_d),
        .zero_we    (zero_we),
        .carry_we   (carry_we),
        .zero_q     (zero_q),
        .carry_q    (carry_q)
    );

    typedef struct packed {
        logic       wr;
        logic       fw;
        logic [7:0] res;
        logic       z;
        logic       c;
    } exp_t;

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0:                 return "R1";
            4'd1, 4'd2, 4'd3:     return "R2";
            4'd4, 4'd6:           return "R3";
            4'd5, 4'd7:           return "R4";
            4'd8:                 return "R5";
            4'd9:                 return "R6";
            4'd10, 4'd11:         return "R7";
            4'd12, 4'd13:         return "R8";
            default:              return "R11";
        endcase
    endfunction

    function automatic exp_t model(input logic [3:0] o, input logic [7:0] a,
                                   input logic [7:0] b, input logic [2:0] sel,
                                   input logic cin, input logic en);
        exp_t e;
        logic [8:0] t;
        logic fill;
        e = '0;
        case (sel)
            3'd1:    fill = 1'b1;
            3'd2:    fill = cin;
            3'd3:    fill = (o == 4'd10) ? a[0] : a[7];
            default: fill = 1'b0;
        endcase
        case (o)
            4'd0: begin e.res = b; e.wr = 1'b1; end
            4'd1: begin e.res = a & b; e.wr = 1'b1; e.fw = 1'b1; end
            4'd2: begin e.res = a | b; e.wr = 1'b1; e.fw = 1'b1; end
            4'd3: begin e.res = a ^ b; e.wr = 1'b1; e.fw = 1'b1; end
            4'd4, 4'd5: begin
                t = {1'b0, a} + {1'b0, b} + ((o == 4'd5) ? {8'd0, cin} : 9'd0);
                e.res = t[7:0]; e.c = t[8]; e.wr = 1'b1; e.fw = 1'b1;
            end
            4'd6, 4'd7, 4'd9: begin
                t = {1'b0, a} - {1'b0, b} - ((o == 4'd7) ? {8'd0, cin} : 9'd0);
                e.res = t[7:0]; e.c = t[8]; e.wr = (o != 4'd9); e.fw = 1'b1;
            end
            4'd8: begin e.res = a & b; e.c = ^(a & b); e.fw = 1'b1; end
            4'd10: begin e.res = {a[6:0], fill}; e.c = a[7]; e.wr = 1'b1; e.fw = 1'b1; end
            4'd11: begin e.res = {fill, a[7:1]}; e.c = a[0]; e.wr = 1'b1; e.fw = 1'b1; end
            4'd12: begin e.res = {a[6:0], a[7]}; e.c = a[7]; e.wr = 1'b1; e.fw = 1'b1; end
            4'd13: begin e.res = {a[0], a[7:1]}; e.c = a[0]; e.wr = 1'b1; e.fw = 1'b1; end
            default: begin end
        endcase
        e.z = (e.res == 8'd0);
        if (!en) begin
            e.wr = 1'b0;
            e.fw = 1'b0;
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic [2:0] sel, input logic en);
        exp_t e;
        string rq;
        @(negedge clk);
        op = o; opnd_a = a; opnd_b = b; shift_fill = sel; exec_en = en;
        #1;
        e  = model(o, a, b, sel, m_c, en);
        rq = en ? req_of(o) : "R9";
        chk(result_we == e.wr, rq, "result_we", {7'd0, result_we}, {7'd0, e.wr});
        chk(zero_we == e.fw && carry_we == e.fw, rq, "flag_we",
            {6'd0, zero_we, carry_we}, {6'd0, e.fw, e.fw});
        if (e.wr) chk(result == e.res, rq, "result", result, e.res);
        if (e.fw) begin
            chk(zero_d == e.z, rq, "zero_d", {7'd0, zero_d}, {7'd0, e.z});
            chk(carry_d == e.c, rq, "carry_d", {7'd0, carry_d}, {7'd0, e.c});
        end
        @(posedge clk);
        #1;
        if (e.fw) begin
            m_z = e.z;
            m_c = e.c;
        end
        chk(zero_q == m_z && carry_q == m_c, e.fw ? rq : "R9", "flags_q",
            {6'd0, zero_q, carry_q}, {6'd0, m_z, m_c});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; exec_en = 1'b0; op = 4'd0; shift_fill = 3'd0;
        opnd_a = 8'd0; opnd_b = 8'd0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset clears flags
        chk(zero_q == 1'b0 && carry_q == 1'b0, "R10", "reset_flags",
            {6'd0, zero_q, carry_q}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 add overflow to zero, then R4 chain with carry-in
        step(4'd4, 8'hFF, 8'h01, 3'd0, 1'b1);
        step(4'd5, 8'h00, 8'h00, 3'd0, 1'b1);
        step(4'd1, 8'h0F, 8'h0F, 3'd0, 1'b1);
        // R1 load leaves flags
        step(4'd6, 8'h00, 8'h01, 3'd0, 1'b1);
        step(4'd0, 8'h12, 8'h00, 3'd0, 1'b1);
        // R4 borrow chain
        step(4'd7, 8'h05, 8'h05, 3'd0, 1'b1);
        step(4'd7, 8'h05, 8'h04, 3'd0, 1'b1);
        // R2 logic zero and carry clear
        step(4'd6, 8'h00, 8'h01, 3'd0, 1'b1);
        step(4'd1, 8'hF0, 8'h0F, 3'd0, 1'b1);
        step(4'd2, 8'h80, 8'h01, 3'd0, 1'b1);
        step(4'd3, 8'hAA, 8'hAA, 3'd0, 1'b1);
        // R5 parity
        step(4'd8, 8'h07, 8'hFF, 3'd0, 1'b1);
        step(4'd8, 8'h03, 8'h03, 3'd0, 1'b1);
        step(4'd8, 8'hF0, 8'h0F, 3'd0, 1'b1);
        // R6 compare
        step(4'd9, 8'h40, 8'h40, 3'd0, 1'b1);
        step(4'd9, 8'h10, 8'h40, 3'd0, 1'b1);
        // R7 every fill selector both ways, carry fill chained
        for (int s = 0; s < 8; s++) begin
            step(4'd10, 8'hA5, 8'h00, 3'(s), 1'b1);
            step(4'd11, 8'h5A, 8'h00, 3'(s), 1'b1);
            step(4'd10, 8'h81, 8'h00, 3'd2, 1'b1);
            step(4'd11, 8'h01, 8'h00, 3'd2, 1'b1);
        end
        step(4'd10, 8'h80, 8'h00, 3'd0, 1'b1);
        // R8 rotates ignore selector
        step(4'd12, 8'h81, 8'h00, 3'd1, 1'b1);
        step(4'd13, 8'h01, 8'h00, 3'd2, 1'b1);
        step(4'd13, 8'h00, 8'h00, 3'd1, 1'b1);
        // R9 idle cycles keep flags
        step(4'd4, 8'hFF, 8'hFF, 3'd0, 1'b0);
        step(4'd1, 8'h00, 8'h00, 3'd0, 1'b0);
        // R11 unassigned codes
        step(4'd14, 8'h00, 8'h00, 3'd0, 1'b1);
        step(4'd15, 8'hFF, 8'h01, 3'd0, 1'b1);

        for (int i = 0; i < 4000; i++) begin
            step(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
                 3'($urandom_range(0, 7)), ($urandom_range(0, 9) != 0));
        end

        // R10 reset again after activity
        step(4'd4, 8'hFF, 8'h01, 3'd0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk(zero_q == 1'b0 && carry_q == 1'b0, "R10", "reset_flags_again",
            {6'd0, zero_q, carry_q}, 8'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule